// File: doc/BRIEF.md
# Predicated Vector Element Step Sequencer

This block walks the element loop of one vector-prefixed instruction. It keeps a 32-bit vector state word that packs a maximum length, the current vector length, a source step, a destination step, a sub-vector length and a step count. On every element issue it moves the source and destination steps forward past elements whose predicate bit is clear. It tells the execution side which element pair to run and whether either side has to be written as zero. It also tells the fetch side whether the program counter must stay on the current instruction or may go on to the next one.

Each side has its own predicate mask and its own zeroing flag, and the two sides skip independently. In twin-predicate mode the loop counts as vector when either operand is a vector; in single-predicate mode only the destination counts. A vertical-first flag stops the loop from holding the program counter. In that mode the steps only move when an explicit step request arrives, and a step request that reaches the end of the loop leaves vertical-first mode. The masks come from outside the block, and so do the vector/scalar classification and the decision to issue.

Top module: `vec_step_seq`

## Requirements
- R1: A state write loads the whole state word and the vertical-first flag on the next edge. The word is read back on `stateOut` with bit 31 as the most significant bit: max length in [31:25], vector length in [24:18], source step in [17:11], destination step in [10:4], sub-vector length in [3:2] and step count in [1:0]. The sequencer never alters max length, sub-vector length or step count.
- R2: After reset the state word is zero, vertical-first is 0, `issueReady` is 1 and `elemValid`, `holdPc`, `srcZero` and `dstZero` are 0.
- R3: On a source side that is not in zeroing mode, the reported source step is the lowest position p such that the stored step <= p < vector length and the source mask has bit p set. Mask positions 64 and above count as clear. If there is no such p, the step becomes the vector length.
- R4: The destination step is skipped in the same way against the destination mask, independently of the source side.
- R5: On a side in zeroing mode the step is not skipped. That side's zero output is 1 for an issued element exactly when its mask bit at the step is clear.
- R6: If after skipping either step is at or beyond the vector length (this includes a vector length of 0), the issue executes no element. `elemValid` and `holdPc` stay 0 and both stored steps return to 0.
- R7: If an element executes outside vertical-first mode, the loop is vector and neither step equals length-1, then `holdPc` is 1 and both stored steps become the skipped steps plus one. Otherwise `holdPc` is 0 and both stored steps return to 0.
- R8: With `twinPred`=0 the loop counts as vector only when `dstIsVec`=1. With `twinPred`=1 it counts as vector when `srcIsVec` or `dstIsVec` is 1.
- R9: With `predEnable`=0 both masks are taken as all ones over 64 positions, whatever the mask inputs carry.
- R10: In vertical-first mode an executed element gives `holdPc`=0. The stored steps become the skipped steps without any increment, and vertical-first stays set.
- R11: A step request first skips both steps as an issue would. If that completes the loop, or if either skipped step equals length-1, both steps return to 0 and vertical-first clears. Otherwise both stored steps become the skipped steps plus one.
- R12: A state write takes priority over a step request, and a step request takes priority over an issue. `issueReady` is 0 whenever `stateWrEn` or `stepReq` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stateWrEn | input | 1 | Load the state word and vertical-first flag |
| stateWrData | input | 32 | State word to load |
| vfWrData | input | 1 | Vertical-first value to load |
| predEnable | input | 1 | 1: use the mask inputs; 0: treat masks as all ones |
| twinPred | input | 1 | 1: twin-predicate mode; 0: single-predicate mode |
| srcMask | input | 64 | Source predicate mask, bit i for element i |
| dstMask | input | 64 | Destination predicate mask |
| srcZeroMode | input | 1 | Source side zeroing mode |
| dstZeroMode | input | 1 | Destination side zeroing mode |
| srcIsVec | input | 1 | Source operand is a vector |
| dstIsVec | input | 1 | Destination operand is a vector |
| issueValid | input | 1 | Request to issue the current element |
| issueReady | output | 1 | Issue can be accepted this cycle |
| stepReq | input | 1 | Explicit step request (vertical-first) |
| elemValid | output | 1 | An element executes on this issue |
| srcStep | output | 7 | Skipped source step for this cycle |
| dstStep | output | 7 | Skipped destination step for this cycle |
| srcZero | output | 1 | Source element must be taken as zero |
| dstZero | output | 1 | Destination element must be written as zero |
| holdPc | output | 1 | Keep the program counter on this instruction |
| stateOut | output | 32 | Current state word |
| vertFirst | output | 1 | Vertical-first mode flag |

## Verification
The bench uses sparse masks so that the two sides skip different distances and complete the loop on different elements. A design that tied the sides together, or that skipped only one element per issue, would report the wrong step pair. One mask has its only bits near position 64 with a length of 100, so a search that wrapped or read past the mask would land on a phantom element. Other cases use a length of 0, a zeroing side with a clear bit at the step, and a loop in which only the source is a vector. These catch a design that runs an element when it should finish, that skips in zeroing mode, or that holds the PC on a scalar destination under single predication. A vertical-first pass checks that issue stores the step without incrementing it, and that the step request which reaches length-1 clears both steps and the mode.

// File: rtl/vss_pkg.sv
package vss_pkg;
  localparam int STEP_W = 7;
  localparam int SUB_W  = 2;
  localparam int MASK_W = 64;

  // MSB-first packed order gives max length in the top bits
  typedef struct packed {
    logic [STEP_W-1:0] maxLen;
    logic [STEP_W-1:0] vecLen;
    logic [STEP_W-1:0] srcStep;
    logic [STEP_W-1:0] dstStep;
    logic [SUB_W-1:0]  subLen;
    logic [SUB_W-1:0]  stepCnt;
  } vstate_t;

  localparam int STATE_W = $bits(vstate_t);

  // control -> datapath strobes
  typedef struct packed {
    logic loadState;
    logic clearSteps;
    logic advance;
    logic settle;
    logic vfClear;
  } strobe_t;

  // datapath -> control status
  typedef struct packed {
    logic done;
    logic srcLast;
    logic dstLast;
  } flags_t;
endpackage

// File: rtl/vss_skip.sv
module vss_skip #(
  parameter int MASK_W = vss_pkg::MASK_W,
  parameter int STEP_W = vss_pkg::STEP_W
) (
  input  logic [STEP_W-1:0] curStep,
  input  logic [STEP_W-1:0] vecLen,
  input  logic [MASK_W-1:0] mask,
  input  logic              zeroMode,
  output logic [STEP_W-1:0] nextStep,
  output logic              zeroFlag
);
  logic [STEP_W-1:0] hit;
  logic              curBit;

  // lowest set mask bit in [curStep, vecLen); falls back to vecLen
  always_comb begin
    hit    = vecLen;
    curBit = 1'b0;
    for (int i = MASK_W - 1; i >= 0; i--) begin
      if (mask[i] && (int'(curStep) <= i) && (i < int'(vecLen))) begin
        hit = STEP_W'(i);
      end
      if (int'(curStep) == i) begin
        curBit = mask[i];
      end
    end
  end

  assign nextStep = zeroMode ? curStep : hit;
  assign zeroFlag = zeroMode & ~curBit;
endmodule

// File: rtl/vss_datapath.sv
module vss_datapath #(
  parameter int MASK_W = vss_pkg::MASK_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  vss_pkg::strobe_t             strobe,
  input  logic [vss_pkg::STATE_W-1:0]  stateWrData,
  input  logic                         vfWrData,
  input  logic                         predEnable,
  input  logic [MASK_W-1:0]            srcMask,
  input  logic [MASK_W-1:0]            dstMask,
  input  logic                         srcZeroMode,
  input  logic                         dstZeroMode,
  output logic [vss_pkg::STEP_W-1:0]   srcNew,
  output logic [vss_pkg::STEP_W-1:0]   dstNew,
  output logic                         srcZeroRaw,
  output logic                         dstZeroRaw,
  output vss_pkg::flags_t              flags,
  output logic [vss_pkg::STATE_W-1:0]  stateOut,
  output logic                         vertFirst
);
  import vss_pkg::*;
  localparam int SIDES = 2;
  localparam logic [STEP_W-1:0] ONE = STEP_W'(1);

  vstate_t stateQ;
  logic    vfQ;

  logic [STEP_W-1:0] curStep  [SIDES];
  logic [STEP_W-1:0] newStep  [SIDES];
  logic [MASK_W-1:0] sideMask [SIDES];
  logic              sideZm   [SIDES];
  logic              sideZf   [SIDES];

  assign curStep[0]  = stateQ.srcStep;
  assign curStep[1]  = stateQ.dstStep;
  assign sideMask[0] = predEnable ? srcMask : '1;
  assign sideMask[1] = predEnable ? dstMask : '1;
  assign sideZm[0]   = srcZeroMode;
  assign sideZm[1]   = dstZeroMode;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    vss_skip #(.MASK_W(MASK_W), .STEP_W(STEP_W)) u_skip (
      .curStep (curStep[s]),
      .vecLen  (stateQ.vecLen),
      .mask    (sideMask[s]),
      .zeroMode(sideZm[s]),
      .nextStep(newStep[s]),
      .zeroFlag(sideZf[s])
    );
  end

  assign srcNew     = newStep[0];
  assign dstNew     = newStep[1];
  assign srcZeroRaw = sideZf[0];
  assign dstZeroRaw = sideZf[1];

  assign flags.done    = (newStep[0] >= stateQ.vecLen) || (newStep[1] >= stateQ.vecLen);
  assign flags.srcLast = (newStep[0] == stateQ.vecLen - ONE);
  assign flags.dstLast = (newStep[1] == stateQ.vecLen - ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= '0;
      vfQ    <= 1'b0;
    end else if (strobe.loadState) begin
      stateQ <= vstate_t'(stateWrData);
      vfQ    <= vfWrData;
    end else begin
      if (strobe.clearSteps) begin
        stateQ.srcStep <= '0;
        stateQ.dstStep <= '0;
      end else if (strobe.advance) begin
        stateQ.srcStep <= newStep[0] + ONE;
        stateQ.dstStep <= newStep[1] + ONE;
      end else if (strobe.settle) begin
        stateQ.srcStep <= newStep[0];
        stateQ.dstStep <= newStep[1];
      end
      if (strobe.vfClear) begin
        vfQ <= 1'b0;
      end
    end
  end

  assign stateOut  = stateQ;
  assign vertFirst = vfQ;
endmodule

// File: rtl/vss_ctrl.sv
module vss_ctrl (
  input  logic             stateWrEn,
  input  logic             stepReq,
  input  logic             issueValid,
  input  logic             vertFirst,
  input  logic             twinPred,
  input  logic             srcIsVec,
  input  logic             dstIsVec,
  input  vss_pkg::flags_t  flags,
  output vss_pkg::strobe_t strobe,
  output logic             issueReady,
  output logic             elemValid,
  output logic             holdPc
);
  logic issueFire;
  logic stepFire;
  logic isVec;
  logic atLast;
  logic stepEnds;

  assign issueReady = ~stateWrEn & ~stepReq;
  assign issueFire  = issueValid & issueReady;
  assign stepFire   = stepReq & ~stateWrEn;
  assign isVec      = twinPred ? (srcIsVec | dstIsVec) : dstIsVec;
  assign atLast     = flags.srcLast | flags.dstLast;
  assign stepEnds   = flags.done | atLast;

  assign elemValid  = issueFire & ~flags.done;
  assign holdPc     = elemValid & ~vertFirst & isVec & ~atLast;

  always_comb begin
    strobe            = '0;
    strobe.loadState  = stateWrEn;
    strobe.clearSteps = (issueFire & (flags.done | (~vertFirst & ~holdPc)))
                      | (stepFire & stepEnds);
    strobe.advance    = holdPc | (stepFire & ~stepEnds);
    strobe.settle     = elemValid & vertFirst;
    strobe.vfClear    = stepFire & stepEnds;
  end
endmodule

// File: rtl/vec_step_seq.sv
module vec_step_seq (
  input  logic        clk,
  input  logic        rstN,
  input  logic        stateWrEn,
  input  logic [31:0] stateWrData,
  input  logic        vfWrData,
  input  logic        predEnable,
  input  logic        twinPred,
  input  logic [63:0] srcMask,
  input  logic [63:0] dstMask,
  input  logic        srcZeroMode,
  input  logic        dstZeroMode,
  input  logic        srcIsVec,
  input  logic        dstIsVec,
  input  logic        issueValid,
  output logic        issueReady,
  input  logic        stepReq,
  output logic        elemValid,
  output logic [6:0]  srcStep,
  output logic [6:0]  dstStep,
  output logic        srcZero,
  output logic        dstZero,
  output logic        holdPc,
  output logic [31:0] stateOut,
  output logic        vertFirst
);
  import vss_pkg::*;

  strobe_t strobe;
  flags_t  flags;
  logic    srcZeroRaw;
  logic    dstZeroRaw;

  vss_ctrl u_ctrl (
    .stateWrEn (stateWrEn),
    .stepReq   (stepReq),
    .issueValid(issueValid),
    .vertFirst (vertFirst),
    .twinPred  (twinPred),
    .srcIsVec  (srcIsVec),
    .dstIsVec  (dstIsVec),
    .flags     (flags),
    .strobe    (strobe),
    .issueReady(issueReady),
    .elemValid (elemValid),
    .holdPc    (holdPc)
  );

  vss_datapath #(.MASK_W(MASK_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .stateWrData(stateWrData),
    .vfWrData   (vfWrData),
    .predEnable (predEnable),
    .srcMask    (srcMask),
    .dstMask    (dstMask),
    .srcZeroMode(srcZeroMode),
    .dstZeroMode(dstZeroMode),
    .srcNew     (srcStep),
    .dstNew     (dstStep),
    .srcZeroRaw (srcZeroRaw),
    .dstZeroRaw (dstZeroRaw),
    .flags      (flags),
    .stateOut   (stateOut),
    .vertFirst  (vertFirst)
  );

  assign srcZero = elemValid & srcZeroRaw;
  assign dstZero = elemValid & dstZeroRaw;
endmodule

// File: rtl/vss_chk.sv
module vss_chk (
  input logic        clk,
  input logic        rstN,
  input logic        stateWrEn,
  input logic        predEnable,
  input logic [63:0] srcMask,
  input logic        srcZeroMode,
  input logic        stepReq,
  input logic        issueReady,
  input logic        elemValid,
  input logic [6:0]  srcStep,
  input logic [6:0]  dstStep,
  input logic        srcZero,
  input logic        holdPc,
  input logic [31:0] stateOut,
  input logic        vertFirst
);
  vss_pkg::vstate_t st;
  assign st = stateOut;

  assert_hold_needs_elem_R7: assert property (@(posedge clk) disable iff (!rstN)
    holdPc |-> elemValid);

  assert_hold_advances_R7: assert property (@(posedge clk) disable iff (!rstN)
    holdPc |=> (st.srcStep == $past(srcStep) + 7'd1) && (st.dstStep == $past(dstStep) + 7'd1));

  assert_elem_in_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    elemValid |-> (srcStep < st.vecLen) && (dstStep < st.vecLen));

  assert_vf_never_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    vertFirst |-> !holdPc);

  assert_priority_R12: assert property (@(posedge clk) disable iff (!rstN)
    (stateWrEn || stepReq) |-> !issueReady);

  assert_skip_lands_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (elemValid && predEnable && !srcZeroMode) |-> |(srcMask & (64'd1 << srcStep)));

  assert_zero_needs_mode_R5: assert property (@(posedge clk) disable iff (!rstN)
    srcZero |-> (srcZeroMode && elemValid));
endmodule

bind vec_step_seq vss_chk u_chk (.*);

// File: tb/tb_vec_step_seq.sv
`timescale 1ns/1ps
module tb_vec_step_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stateWrEn = 1'b0;
  logic [31:0] stateWrData = '0;
  logic        vfWrData = 1'b0;
  logic        predEnable = 1'b0;
  logic        twinPred = 1'b0;
  logic [63:0] srcMask = '0;
  logic [63:0] dstMask = '0;
  logic        srcZeroMode = 1'b0;
  logic        dstZeroMode = 1'b0;
  logic        srcIsVec = 1'b0;
  logic        dstIsVec = 1'b0;
  logic        issueValid = 1'b0;
  logic        issueReady;
  logic        stepReq = 1'b0;
  logic        elemValid;
  logic [6:0]  srcStep;
  logic [6:0]  dstStep;
  logic        srcZero;
  logic        dstZero;
  logic        holdPc;
  logic [31:0] stateOut;
  logic        vertFirst;

  int errors = 0;
  int checks = 0;

  // values captured during an issue
  logic       cEv, cHold, cSz, cDz;
  logic [6:0] cSrc, cDst;

  always #4 clk = ~clk;

  vec_step_seq dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] stSrc();
    return stateOut[17:11];
  endfunction
  function automatic logic [6:0] stDst();
    return stateOut[10:4];
  endfunction

  task automatic writeState(input logic [6:0] len, input logic [6:0] s,
                            input logic [6:0] d, input logic vf);
    @(negedge clk);
    stateWrEn   = 1'b1;
    stateWrData = {7'h55, len, s, d, 2'b10, 2'b01};
    vfWrData    = vf;
    @(posedge clk);
    #1 stateWrEn = 1'b0;
  endtask

  task automatic doIssue();
    @(negedge clk);
    issueValid = 1'b1;
    #1;
    cEv = elemValid; cHold = holdPc; cSz = srcZero; cDz = dstZero;
    cSrc = srcStep; cDst = dstStep;
    @(posedge clk);
    #1 issueValid = 1'b0;
  endtask

  task automatic doStep();
    @(negedge clk);
    stepReq = 1'b1;
    @(posedge clk);
    #1 stepReq = 1'b0;
  endtask

  task automatic testReset();
    #1;
    chk("R2 state", stateOut, 0);
    chk("R2 vf", vertFirst, 0);
    chk("R2 ready", issueReady, 1);
    chk("R2 outputs", {elemValid, holdPc, srcZero, dstZero}, 0);
  endtask

  task automatic testLayout();
    writeState(7'd9, 7'd3, 7'd6, 1'b0);
    chk("R1 word", stateOut, {7'h55, 7'd9, 7'd3, 7'd6, 2'b10, 2'b01});
    chk("R1 src field", stSrc(), 3);
    chk("R1 dst field", stDst(), 6);
  endtask

  task automatic testHorizontal();
    predEnable = 0; twinPred = 0; srcIsVec = 0; dstIsVec = 1;
    srcMask = '0; dstMask = '0;  // ignored when predication is off
    writeState(7'd4, 7'd0, 7'd0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      doIssue();
      chk("R9 elem with zero masks", cEv, 1);
      chk("R7 src step", cSrc, 7'(k));
      chk("R7 dst step", cDst, 7'(k));
      chk("R7 hold", cHold, (k < 3) ? 1 : 0);
    end
    chk("R7 cleared at end", {stSrc(), stDst()}, 0);
    chk("R1 untouched fields", {stateOut[31:25], stateOut[3:0]}, {7'h55, 4'b1001});
  endtask

  task automatic testSkip();
    predEnable = 1; twinPred = 1; srcIsVec = 1; dstIsVec = 1;
    srcMask = 64'hA4; dstMask = 64'h42;
    writeState(7'd8, 7'd0, 7'd0, 1'b0);
    doIssue();
    chk("R3 src skip first", cSrc, 2);
    chk("R4 dst skip first", cDst, 1);
    chk("R7 hold first", cHold, 1);
    chk("R7 stored steps", {stSrc(), stDst()}, {7'd3, 7'd2});
    doIssue();
    chk("R3 src skip second", cSrc, 5);
    chk("R4 dst skip second", cDst, 6);
    doIssue();
    chk("R6 dst runs out", {cEv, cHold}, 0);
    chk("R6 steps cleared", {stSrc(), stDst()}, 0);
    // mask bits near the 64 boundary, length 100
    srcMask = 64'h1 << 62; dstMask = 64'h1 << 63;
    writeState(7'd100, 7'd60, 7'd63, 1'b0);
    doIssue();
    chk("R3 src high skip", cSrc, 62);
    chk("R4 dst at bit63", cDst, 63);
    chk("R7 hold high", cHold, 1);
    doIssue();
    chk("R3 positions >=64 clear", {cEv, cHold}, 0);
    chk("R3 cleared after", {stSrc(), stDst()}, 0);
  endtask

  task automatic testZeroing();
    predEnable = 1; twinPred = 0; dstIsVec = 1; srcZeroMode = 1; dstZeroMode = 0;
    srcMask = 64'h1; dstMask = '1;
    writeState(7'd3, 7'd0, 7'd0, 1'b0);
    doIssue();
    chk("R5 set bit no zero", {cSrc, cSz}, {7'd0, 1'b0});
    doIssue();
    chk("R5 no skip in zero mode", cSrc, 1);
    chk("R5 zero flag", cSz, 1);
    chk("R5 other side not zeroed", cDz, 0);
    srcZeroMode = 0;
  endtask

  task automatic testLenZero();
    predEnable = 0; dstIsVec = 1;
    writeState(7'd0, 7'd0, 7'd0, 1'b0);
    doIssue();
    chk("R6 length zero", {cEv, cHold}, 0);
  endtask

  task automatic testVecClass();
    predEnable = 0; twinPred = 0; srcIsVec = 1; dstIsVec = 0;
    writeState(7'd4, 7'd0, 7'd0, 1'b0);
    doIssue();
    chk("R8 single scalar dst", {cEv, cHold}, 2'b10);
    chk("R8 single scalar clears", {stSrc(), stDst()}, 0);
    twinPred = 1;
    doIssue();
    chk("R8 twin src vector", {cEv, cHold}, 2'b11);
    dstIsVec = 1; twinPred = 0;
  endtask

  task automatic testVertical();
    predEnable = 1; twinPred = 0; dstIsVec = 1;
    srcMask = ~64'h1; dstMask = ~64'h3;
    writeState(7'd4, 7'd0, 7'd0, 1'b1);
    doIssue();
    chk("R10 elem", cEv, 1);
    chk("R10 no hold", cHold, 0);
    chk("R10 steps", {cSrc, cDst}, {7'd1, 7'd2});
    chk("R10 stored no inc", {stSrc(), stDst()}, {7'd1, 7'd2});
    chk("R10 vf kept", vertFirst, 1);
    doStep();
    chk("R11 step advance", {stSrc(), stDst()}, {7'd2, 7'd3});
    chk("R11 vf still set", vertFirst, 1);
    doStep();
    chk("R11 end clears steps", {stSrc(), stDst()}, 0);
    chk("R11 end clears vf", vertFirst, 0);
  endtask

  task automatic testPriority();
    predEnable = 0; dstIsVec = 1;
    writeState(7'd4, 7'd1, 7'd1, 1'b0);
    @(negedge clk);
    issueValid = 1; stepReq = 1; #1;
    chk("R12 step blocks issue", {issueReady, elemValid}, 0);
    @(posedge clk); #1;
    chk("R12 step wins", {stSrc(), stDst()}, {7'd2, 7'd2});
    @(negedge clk);
    stepReq = 0; stateWrEn = 1;
    stateWrData = {7'h55, 7'd5, 7'd0, 7'd0, 2'b10, 2'b01};
    #1;
    chk("R12 write blocks issue", issueReady, 0);
    @(posedge clk); #1;
    stateWrEn = 0; issueValid = 0;
    chk("R12 write wins", {stateOut[24:18], stSrc(), stDst()}, {7'd5, 7'd0, 7'd0});
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    @(posedge clk); @(posedge clk);
    testReset();
    @(negedge clk) rstN = 1'b1;
    testLayout();
    testHorizontal();
    testSkip();
    testZeroing();
    testLenZero();
    testVecClass();
    testVertical();
    testPriority();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule